// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events and clock cycles for performance analysis. It holds a parameterised bank of 32-bit event counters and one 64-bit cycle counter, which always sits at counter index 31. Each event counter has its own event-type register. The type selects one of the plain strobe inputs `evt_i`, or it selects the software-increment event, where a register write advances the counter.

Software sets up the unit through a flat register port. Writes are synchronous, and reads are combinational from the current state. A selector register steers the indirect counter-value and event-type registers to one counter. A global control register enables counting, pulses the counter resets, turns on a divide-by-64 prescaler for the cycle counter, and chooses whether the cycle counter overflows at 32 or at 64 bits. When a counter wraps, it sets its bit in an overflow-status mask. Overflow bits that are also enabled in the interrupt-enable mask drive a level-sensitive interrupt.

Register addresses on `reg_addr_i`: 0 control, 1 count-enable mask, 2 overflow status, 3 interrupt-enable mask, 4 selector, 5 selected counter bits 31:0, 6 selected counter bits 63:32, 7 selected event type, 8 software increment. In every mask, bit i belongs to event counter i and bit 31 belongs to the cycle counter.

Top module: `pmu_counter_unit`

## Requirements
- R1: Selector value 31 addresses the cycle counter, and values 0 to N_CTR-1 address event counters. Any other selector value reads 0 through the counter and type registers, and writes to it change no counter.
- R2: Control register bits: 0 global enable, 1 event-counter reset, 2 cycle-counter reset, 3 divider, 4 long cycle counter. The two reset bits always read 0. Bits 15:11 read N_CTR, bits 23:16 read ID_CODE and bits 31:24 read IMP_CODE, and writes do not change these fields.
- R3: A counter advances only while the global enable bit and its own count-enable bit are both 1.
- R4: An event type t in 1..N_EVT counts pulses on `evt_i[t-1]`. Type 0 counts writes of 1 to bit i of the software-increment register, for counter i, and only while that counter is enabled. A software-increment write has no effect on a counter whose type is not 0.
- R5: The event-counter reset bit clears every event counter and leaves the cycle counter unchanged. The cycle-counter reset bit clears the cycle counter and its prescaler. A reset takes precedence over counting in the same cycle.
- R6: With the divider bit set, the cycle counter advances once every 64 enabled clocks. The first step comes on the 64th clock after a cycle-counter reset.
- R7: With the long bit at 0, the cycle counter reports overflow when its bits 31:0 wrap, while it keeps counting into bits 63:32. With the long bit at 1, it reports overflow only when all 64 bits wrap.
- R8: An overflow sets its counter's bit in the overflow-status register. Writing 1 to a status bit clears it. An overflow in the same cycle wins over the clear.
- R9: `irq_o` is high exactly while some overflow-status bit has its interrupt-enable bit set.
- R10: The selector is 5 bits wide and the event type is 10 bits wide. The enable, status and interrupt masks keep only the bits of implemented counters. The software-increment register and the type register of the cycle counter read 0.
- R11: After reset, every counter, mask, type and control bit is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| evt_i | input | N_EVT | Event strobes, one count per high cycle |
| irq_o | output | 1 | Level-sensitive overflow interrupt |

## Verification
Any corrupted state reaches the port by the next clock edge. A counter that misses or doubles a step shows a wrong value in the first read after the burst. A prescaler that is off by one moves the first divided step away from the 64th clock, which the bench probes on both sides. A wrong overflow threshold sets or withholds status bit 31 at the exact wrap cycle, and `irq_o` follows the status register in the same cycle it changes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int REG_AW  = 4;
    localparam int EVT_W   = 10;
    localparam int SEL_W   = 5;
    localparam int CYC_IDX = 31;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL   = 4'd0,
        A_CNTEN  = 4'd1,
        A_OVF    = 4'd2,
        A_INTEN  = 4'd3,
        A_SEL    = 4'd4,
        A_CNTLO  = 4'd5,
        A_CNTHI  = 4'd6,
        A_EVTYPE = 4'd7,
        A_SWINC  = 4'd8
    } reg_addr_e;

    localparam int CB_EN     = 0;
    localparam int CB_EVRST  = 1;
    localparam int CB_CYCRST = 2;
    localparam int CB_DIV    = 3;
    localparam int CB_LONG   = 4;

    typedef struct packed {
        logic en;
        logic div;
        logic longc;
    } ctrl_t;

    function automatic logic [31:0] ctrl_read(ctrl_t c, logic [4:0] n,
                                              logic [7:0] id, logic [7:0] imp);
        logic [31:0] r;
        r = '0;
        r[CB_EN]   = c.en;
        r[CB_DIV]  = c.div;
        r[CB_LONG] = c.longc;
        r[15:11]   = n;
        r[23:16]   = id;
        r[31:24]   = imp;
        return r;
    endfunction

endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
    import pmu_pkg::*;
#(
    parameter int CW  = 32,
    parameter int NEV = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cnt_en_i,
    input  logic             clr_i,
    input  logic             val_we_i,
    input  logic [CW-1:0]    val_i,
    input  logic             type_we_i,
    input  logic [EVT_W-1:0] type_i,
    input  logic [NEV-1:0]   evt_i,
    input  logic             swinc_i,
    output logic [CW-1:0]    cnt_o,
    output logic [EVT_W-1:0] type_o,
    output logic             ovf_o
);

    logic [CW-1:0]    cnt_q;
    logic [EVT_W-1:0] type_q;
    logic             hit;
    logic             step;

    always_comb begin
        hit = 1'b0;
        if (type_q == '0) begin
            hit = swinc_i;
        end else begin
            for (int e = 0; e < NEV; e++) begin
                if (type_q == EVT_W'(e + 1)) hit = evt_i[e];
            end
        end
    end

    assign step  = cnt_en_i & hit;
    assign ovf_o = step & (&cnt_q) & ~clr_i & ~val_we_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            type_q <= '0;
        end else begin
            if (clr_i)         cnt_q <= '0;
            else if (val_we_i) cnt_q <= val_i;
            else if (step)     cnt_q <= cnt_q + 1'b1;
            if (type_we_i)     type_q <= type_i;
        end
    end

    assign cnt_o  = cnt_q;
    assign type_o = type_q;

    AST_EVT_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> cnt_q == '0); // R5
    AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cnt_en_i && !clr_i && !val_we_i) |=> $stable(cnt_q)); // R3
    AST_EVT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_o |=> cnt_q == '0); // R8

endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
    import pmu_pkg::*;
#(
    parameter int DIV_LOG2 = 6
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        cnt_en_i,
    input  logic        div_i,
    input  logic        long_i,
    input  logic        clr_i,
    input  logic        lo_we_i,
    input  logic        hi_we_i,
    input  logic [31:0] wdata_i,
    output logic [63:0] cnt_o,
    output logic        ovf_o
);

    logic [63:0]         cnt_q;
    logic [DIV_LOG2-1:0] pre_q;
    logic                tick;
    logic                wr_any;

    assign wr_any = lo_we_i | hi_we_i;
    assign tick   = cnt_en_i & (~div_i | (&pre_q));
    assign ovf_o  = tick & ~clr_i & ~wr_any &
                    (long_i ? (&cnt_q) : (&cnt_q[31:0]));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else begin
            if (cnt_en_i && div_i) pre_q <= pre_q + 1'b1;
            if (wr_any) begin
                if (lo_we_i) cnt_q[31:0]  <= wdata_i;
                if (hi_we_i) cnt_q[63:32] <= wdata_i;
            end else if (tick) begin
                cnt_q <= cnt_q + 64'd1;
            end
        end
    end

    assign cnt_o = cnt_q;

    AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_en_i && div_i && !(&pre_q) && !clr_i && !wr_any) |=> $stable(cnt_q)); // R6
    AST_LONG_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovf_o && long_i) |=> cnt_q == '0); // R7
    AST_SHORT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_o |=> cnt_q[31:0] == '0); // R7

endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
    import pmu_pkg::*;
#(
    parameter int         N_CTR    = 4,
    parameter int         N_EVT    = 8,
    parameter logic [7:0] ID_CODE  = 8'h5A,
    parameter logic [7:0] IMP_CODE = 8'h3C
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [N_EVT-1:0]  evt_i,
    output logic              irq_o
);

    localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << N_CTR) - 32'd1);

    ctrl_t             ctrl_q;
    logic [31:0]       cnten_q, ovf_q, inten_q;
    logic [SEL_W-1:0]  sel_q;
    logic [31:0]       evt_cnt  [N_CTR];
    logic [EVT_W-1:0]  evt_type [N_CTR];
    logic [N_CTR-1:0]  evt_ovf;
    logic              cyc_ovf;
    logic [63:0]       cyc_cnt;
    logic [31:0]       ovf_set;
    logic              wr_ctrl, sel_cyc, sel_evt;

    assign wr_ctrl = reg_we_i && reg_addr_i == A_CTRL;
    assign sel_cyc = sel_q == SEL_W'(CYC_IDX);
    assign sel_evt = 32'(sel_q) < N_CTR;

    for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
        pmu_evt_ctr #(.CW(32), .NEV(N_EVT)) u_ctr (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .cnt_en_i  (ctrl_q.en & cnten_q[g]),
            .clr_i     (wr_ctrl & reg_wdata_i[CB_EVRST]),
            .val_we_i  (reg_we_i && reg_addr_i == A_CNTLO && sel_q == SEL_W'(g)),
            .val_i     (reg_wdata_i),
            .type_we_i (reg_we_i && reg_addr_i == A_EVTYPE && sel_q == SEL_W'(g)),
            .type_i    (reg_wdata_i[EVT_W-1:0]),
            .evt_i     (evt_i),
            .swinc_i   (reg_we_i && reg_addr_i == A_SWINC && reg_wdata_i[g]),
            .cnt_o     (evt_cnt[g]),
            .type_o    (evt_type[g]),
            .ovf_o     (evt_ovf[g])
        );
    end

    pmu_cyc_ctr #(.DIV_LOG2(6)) u_cyc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cnt_en_i (ctrl_q.en & cnten_q[CYC_IDX]),
        .div_i    (ctrl_q.div),
        .long_i   (ctrl_q.longc),
        .clr_i    (wr_ctrl & reg_wdata_i[CB_CYCRST]),
        .lo_we_i  (reg_we_i && reg_addr_i == A_CNTLO && sel_cyc),
        .hi_we_i  (reg_we_i && reg_addr_i == A_CNTHI && sel_cyc),
        .wdata_i  (reg_wdata_i),
        .cnt_o    (cyc_cnt),
        .ovf_o    (cyc_ovf)
    );

    always_comb begin
        ovf_set = '0;
        ovf_set[N_CTR-1:0] = evt_ovf;
        ovf_set[CYC_IDX]   = cyc_ovf;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q  <= '0;
            cnten_q <= '0;
            ovf_q   <= '0;
            inten_q <= '0;
            sel_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en    <= reg_wdata_i[CB_EN];
                ctrl_q.div   <= reg_wdata_i[CB_DIV];
                ctrl_q.longc <= reg_wdata_i[CB_LONG];
            end
            if (reg_we_i && reg_addr_i == A_CNTEN) cnten_q <= reg_wdata_i & IMPL_MASK;
            if (reg_we_i && reg_addr_i == A_INTEN) inten_q <= reg_wdata_i & IMPL_MASK;
            if (reg_we_i && reg_addr_i == A_SEL)   sel_q   <= reg_wdata_i[SEL_W-1:0];
            if (reg_we_i && reg_addr_i == A_OVF)
                ovf_q <= (ovf_q & ~reg_wdata_i) | ovf_set;
            else
                ovf_q <= ovf_q | ovf_set;
        end
    end

    assign irq_o = |(ovf_q & inten_q);

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_CTRL:  reg_rdata_o = ctrl_read(ctrl_q, 5'(N_CTR), ID_CODE, IMP_CODE);
            A_CNTEN: reg_rdata_o = cnten_q;
            A_OVF:   reg_rdata_o = ovf_q;
            A_INTEN: reg_rdata_o = inten_q;
            A_SEL:   reg_rdata_o = 32'(sel_q);
            A_CNTLO: begin
                if (sel_cyc) reg_rdata_o = cyc_cnt[31:0];
                for (int i = 0; i < N_CTR; i++)
                    if (sel_q == SEL_W'(i)) reg_rdata_o = evt_cnt[i];
            end
            A_CNTHI: if (sel_cyc) reg_rdata_o = cyc_cnt[63:32];
            A_EVTYPE: begin
                for (int i = 0; i < N_CTR; i++)
                    if (sel_q == SEL_W'(i)) reg_rdata_o = 32'(evt_type[i]);
            end
            default: reg_rdata_o = '0;
        endcase
    end

    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((|(ovf_set & inten_q)) && !(reg_we_i && reg_addr_i == A_INTEN)) |=> irq_o); // R9
    AST_BAD_SEL_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_addr_i == A_CNTLO && !sel_evt && !sel_cyc) |-> reg_rdata_o == '0); // R1
    AST_RST_BITS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_addr_i == A_CTRL) |-> reg_rdata_o[CB_CYCRST:CB_EVRST] == 2'b00); // R2
    AST_OVF_W1C: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_we_i && reg_addr_i == A_OVF && reg_wdata_i[CYC_IDX] && !ovf_set[CYC_IDX])
        |=> !ovf_q[CYC_IDX]); // R8

endmodule

// File: tb/sim_pmu_counter_unit.sv
module sim_pmu_counter_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_CTR = 4;
    localparam int N_EVT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N_EVT-1:0] evt = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    pmu_counter_unit #(.N_CTR(N_CTR), .N_EVT(N_EVT)) u0 (
        .clk_i(clk), .rst_i(rst), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {addr, write data, expected read-back}
    localparam logic [67:0] VEC [9] = '{
        {4'd0, 32'h0000_001F, 32'h3C5A_2019},
        {4'd1, 32'hFFFF_FFFF, 32'h8000_000F},
        {4'd3, 32'hFFFF_FFFF, 32'h8000_000F},
        {4'd4, 32'h0000_00FF, 32'h0000_001F},
        {4'd7, 32'h0000_03FF, 32'h0000_0000},
        {4'd4, 32'h0000_0002, 32'h0000_0002},
        {4'd7, 32'h0000_FFFF, 32'h0000_03FF},
        {4'd8, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd2, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [N_EVT-1:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, cyc_keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(4'd0, v); chk("R11 ctrl", v, 32'h3C5A_2000);
        rd(4'd5, v); chk("R11 counter0", v, 32'h0);
        rd(4'd2, v); chk("R11 ovf", v, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);

        // R10 / R2 register table
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rd(VEC[i][67:64], v);
            chk("R10/R2 table", v, VEC[i][31:0]);
        end
        wr(4'd0, 32'h6); wr(4'd1, 32'h0); wr(4'd3, 32'h0);
        wr(4'd4, 32'h2); wr(4'd7, 32'h0); wr(4'd2, 32'hFFFF_FFFF);

        // R4 event selection
        wr(4'd4, 32'h0); wr(4'd7, 32'h3); wr(4'd1, 32'h1); wr(4'd0, 32'h1);
        for (int k = 0; k < 5; k++) begin
            pulse(8'b0000_0100);
            pulse(8'b0000_0010);
        end
        rd(4'd5, v); chk("R4 event 3 count", v, 32'd5);

        // R3 gating
        wr(4'd1, 32'h0);
        pulse(8'b0000_0100); pulse(8'b0000_0100);
        rd(4'd5, v); chk("R3 count-enable off", v, 32'd5);
        wr(4'd1, 32'h1); wr(4'd0, 32'h0);
        pulse(8'b0000_0100);
        rd(4'd5, v); chk("R3 global off", v, 32'd5);

        // R4 software increment
        wr(4'd0, 32'h1);
        wr(4'd8, 32'h1);
        rd(4'd5, v); chk("R4 swinc ignored on typed counter", v, 32'd5);
        wr(4'd1, 32'h3); wr(4'd4, 32'h1); wr(4'd8, 32'h2);
        rd(4'd5, v); chk("R4 swinc counts", v, 32'd1);
        wr(4'd1, 32'h1); wr(4'd8, 32'h2);
        rd(4'd5, v); chk("R4 swinc disabled", v, 32'd1);

        // R8 / R9 overflow and interrupt
        wr(4'd5, 32'hFFFF_FFFF); wr(4'd1, 32'h2); wr(4'd3, 32'h2);
        chk("R9 irq idle", {31'b0, irq}, 32'h0);
        wr(4'd8, 32'h2);
        rd(4'd5, v); chk("R8 wrap value", v, 32'h0);
        rd(4'd2, v); chk("R8 status set", v, 32'h2);
        chk("R9 irq high", {31'b0, irq}, 32'h1);
        wr(4'd3, 32'h0);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(4'd3, 32'h2);
        chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
        wr(4'd2, 32'h2);
        rd(4'd2, v); chk("R8 w1c", v, 32'h0);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);
        wr(4'd3, 32'h0);

        // R5 cycle reset and plain counting
        wr(4'd4, 32'd31); wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h5);
        rd(4'd5, v); chk("R5 cycle reset", v, 32'h0);
        repeat (10) @(negedge clk);
        rd(4'd5, v); chk("R3 cycle counts", v, 32'd10);

        // R6 divider
        wr(4'd0, 32'hD);
        repeat (63) @(negedge clk);
        rd(4'd5, v); chk("R6 before 64th", v, 32'd0);
        @(negedge clk);
        rd(4'd5, v); chk("R6 at 64th", v, 32'd1);

        // R5 event reset keeps cycle counter
        wr(4'd0, 32'h0);
        rd(4'd5, cyc_keep);
        wr(4'd0, 32'h2);
        wr(4'd4, 32'h0);
        rd(4'd5, v); chk("R5 event cleared", v, 32'h0);
        wr(4'd4, 32'd31);
        rd(4'd5, v); chk("R5 cycle kept", v, cyc_keep);

        // R7 short overflow
        wr(4'd5, 32'hFFFF_FFFD); wr(4'd6, 32'h0); wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd0, 32'h1);
        repeat (2) @(negedge clk);
        rd(4'd2, v); chk("R7 no early ovf", v, 32'h0);
        rd(4'd5, v); chk("R7 low max", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(4'd2, v); chk("R7 short ovf", v, 32'h8000_0000);
        rd(4'd6, v); chk("R7 carry into high", v, 32'h1);

        // R7 long mode
        wr(4'd0, 32'h0); wr(4'd2, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFD);
        wr(4'd0, 32'h11);
        repeat (3) @(negedge clk);
        rd(4'd2, v); chk("R7 long no ovf at 32", v, 32'h0);
        rd(4'd6, v); chk("R7 long high", v, 32'h2);
        wr(4'd0, 32'h0); wr(4'd6, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF);
        wr(4'd0, 32'h11);
        @(negedge clk);
        rd(4'd2, v); chk("R7 long ovf at 64", v, 32'h8000_0000);
        rd(4'd6, v); chk("R7 long wrap high", v, 32'h0);
        wr(4'd0, 32'h0);

        // R1 unimplemented indices
        wr(4'd4, 32'd5); wr(4'd5, 32'h1234);
        rd(4'd5, v); chk("R1 index 5 reads 0", v, 32'h0);
        wr(4'd4, 32'd4); wr(4'd7, 32'h7);
        rd(4'd7, v); chk("R1 index 4 type 0", v, 32'h0);
        rd(4'd5, v); chk("R1 index 4 count 0", v, 32'h0);
        for (int i = 0; i < N_CTR; i++) begin
            wr(4'd4, 32'(i));
            rd(4'd5, v); chk("R1 no stray write", v, 32'h0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule